// File: doc/BRIEF.md
# Drive Health Command Responder

This block sits on the device side of a task-file register interface and answers drive health monitoring commands. The host writes the subcommand selector, the sector count and the two cylinder bytes, then writes the command register. The block acts only when the command byte equals the health opcode. It accepts the command only if the cylinder bytes carry the access signature 4Fh/C2h. It then decodes the selector and updates its three mode flags: health operations, attribute autosave and automatic off-line collection. For the status subcommand it checks a small table of attribute values against their thresholds. It reports a failure by replacing the cylinder bytes with F4h/2Ch.

Register writes arrive as a valid/ready stream. A write transfers on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low from the cycle after a command is accepted until its done cycle ends. While it is low the host must hold its write. Every accepted command spends exactly one cycle busy, then one cycle done, and `err` marks an aborted command in that done cycle. The attribute table has a plain load port, so the host can set the value and threshold of one entry at a time.

Top module: `health_cmd_resp`

## Requirements
- R1: After reset, all three mode flags are 0, both cylinder outputs are 00h, `wr_ready` is 1, and `busy`, `done` and `err` are 0.
- R2: An accepted write with `wr_sel` 0 loads the selector, 1 loads the sector count, 2 loads cylinder low and 3 loads cylinder high. The cylinder registers appear on `cyl_lo_out`/`cyl_hi_out` in the following cycle.
- R3: An accepted write of B0h with `wr_sel` 4 starts a command. `busy` is high for exactly the next cycle, and `done` is high for the one cycle after that. `wr_ready` is low in both of those cycles. A write to `wr_sel` 4 of any other value starts nothing.
- R4: A command issued while the cylinder bytes are not exactly 4Fh (low) and C2h (high) is aborted. `err` is high with `done`, and no flag changes.
- R5: Selector D8h sets the health flag and D9h clears it.
- R6: While the health flag is 0, every selector except D8h aborts.
- R7: Selector D2h with sector count F1h sets the autosave flag, and with 00h clears it. Any other count aborts.
- R8: Selector DBh with sector count F8h sets the off-line flag, and with 00h clears it. Any other count aborts.
- R9: Selector DAh completes without error. If any attribute fails, the cylinder bytes become F4h/2Ch in the done cycle. Otherwise they keep 4Fh/C2h.
- R10: A threshold of 00h never fails and FFh always fails. An entry whose threshold is FEh is skipped. For a threshold from 01h to FDh, the entry fails only when its value is strictly less than the threshold.
- R11: Reserved selectors (D5h, D6h, DCh to DFh) and every other selector not listed above abort with `err`.
- R12: A pulse on `attr_we` loads `attr_value` and `attr_thresh` into the entry chosen by `attr_sel`. After reset every entry holds value 64h and threshold 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write offered |
| wr_ready | output | 1 | Block can take a register write |
| wr_sel | input | 3 | Register select: 0 selector, 1 count, 2 cyl low, 3 cyl high, 4 command |
| wr_data | input | 8 | Register write data |
| attr_we | input | 1 | Load one attribute table entry |
| attr_sel | input | IDX_W | Attribute entry index |
| attr_value | input | 8 | Attribute value to load |
| attr_thresh | input | 8 | Attribute threshold to load |
| cyl_lo_out | output | 8 | Cylinder low register |
| cyl_hi_out | output | 8 | Cylinder high register |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one-cycle strobe) |
| err | output | 1 | Command aborted, valid with done |
| health_en | output | 1 | Health operations enabled |
| autosave_en | output | 1 | Attribute autosave enabled |
| offline_en | output | 1 | Automatic off-line collection enabled |

## Verification
The bench sends a disabled-state status request, which must abort. A responder that skipped the enable check would answer it. It sends a wrong signature on the enable subcommand, which a loose signature compare would let through. It sets a value equal to its threshold, which must pass. An off-by-one compare would report a failure. It loads an FEh threshold above a low value, which must be skipped. A responder that treated FEh as an ordinary threshold would raise a false failure. It also sends sector counts that are neither the set nor the clear code, reserved selectors, and a non-health opcode. Each of these must abort or leave the flags and the busy strobe untouched.

// File: rtl/health_pkg.sv
package health_pkg;
  localparam logic [2:0] SEL_FEAT   = 3'd0;
  localparam logic [2:0] SEL_SCNT   = 3'd1;
  localparam logic [2:0] SEL_CYL_LO = 3'd2;
  localparam logic [2:0] SEL_CYL_HI = 3'd3;
  localparam logic [2:0] SEL_CMD    = 3'd4;

  localparam logic [7:0] SIG_LO  = 8'h4F;
  localparam logic [7:0] SIG_HI  = 8'hC2;
  localparam logic [7:0] FAIL_LO = 8'hF4;
  localparam logic [7:0] FAIL_HI = 8'h2C;

  localparam logic [7:0] SUB_AUTOSAVE = 8'hD2;
  localparam logic [7:0] SUB_ENABLE   = 8'hD8;
  localparam logic [7:0] SUB_DISABLE  = 8'hD9;
  localparam logic [7:0] SUB_STATUS   = 8'hDA;
  localparam logic [7:0] SUB_OFFLINE  = 8'hDB;

  localparam logic [7:0] THR_PASS    = 8'h00;
  localparam logic [7:0] THR_SKIP    = 8'hFE;
  localparam logic [7:0] THR_FAIL    = 8'hFF;
  localparam logic [7:0] VALUE_START = 8'h64;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} state_e;

  typedef enum logic [2:0] {
    ACT_ABORT, ACT_ENABLE, ACT_DISABLE, ACT_STATUS,
    ACT_ASAVE_ON, ACT_ASAVE_OFF, ACT_OFFL_ON, ACT_OFFL_OFF
  } action_e;
endpackage

// File: rtl/hc_regfile.sv
module hc_regfile
  import health_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       set_fail,
  output logic [7:0] feat,
  output logic [7:0] scnt,
  output logic [7:0] cyl_lo,
  output logic [7:0] cyl_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feat   <= '0;
      scnt   <= '0;
      cyl_lo <= '0;
      cyl_hi <= '0;
    end else if (set_fail) begin
      cyl_lo <= FAIL_LO;
      cyl_hi <= FAIL_HI;
    end else if (wr_fire) begin
      case (wr_sel)
        SEL_FEAT:   feat   <= wr_data;
        SEL_SCNT:   scnt   <= wr_data;
        SEL_CYL_LO: cyl_lo <= wr_data;
        SEL_CYL_HI: cyl_hi <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hc_attr_table.sv
module hc_attr_table
  import health_pkg::*;
#(
  parameter int N_ATTR = 4,
  parameter logic [7:0] INIT_THRESH = 8'h00,
  localparam int IDX_W = (N_ATTR > 1) ? $clog2(N_ATTR) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             attr_we,
  input  logic [IDX_W-1:0] attr_sel,
  input  logic [7:0]       attr_value,
  input  logic [7:0]       attr_thresh,
  output logic             exceeded
);
  logic [N_ATTR-1:0] entry_fail;

  for (genvar g = 0; g < N_ATTR; g++) begin : g_entry
    logic [7:0] val_q;
    logic [7:0] thr_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q <= VALUE_START;
        thr_q <= INIT_THRESH;
      end else if (attr_we && attr_sel == IDX_W'(g)) begin
        val_q <= attr_value;
        thr_q <= attr_thresh;
      end
    end

    always_comb begin
      if (thr_q == THR_FAIL)
        entry_fail[g] = 1'b1;
      else if (thr_q == THR_PASS || thr_q == THR_SKIP)
        entry_fail[g] = 1'b0;
      else
        entry_fail[g] = (val_q < thr_q);
    end
  end

  assign exceeded = |entry_fail;
endmodule

// File: rtl/hc_decode.sv
module hc_decode
  import health_pkg::*;
(
  input  logic [7:0] feat,
  input  logic [7:0] scnt,
  input  logic [7:0] cyl_lo,
  input  logic [7:0] cyl_hi,
  input  logic       health_en,
  output action_e    action
);
  logic sig_ok;
  assign sig_ok = (cyl_lo == SIG_LO) && (cyl_hi == SIG_HI);

  always_comb begin
    action = ACT_ABORT;
    if (!sig_ok)
      action = ACT_ABORT;
    else if (feat == SUB_ENABLE)
      action = ACT_ENABLE;
    else if (!health_en)
      action = ACT_ABORT;
    else begin
      case (feat)
        SUB_DISABLE: action = ACT_DISABLE;
        SUB_STATUS:  action = ACT_STATUS;
        SUB_AUTOSAVE: begin
          if (scnt == 8'hF1)      action = ACT_ASAVE_ON;
          else if (scnt == 8'h00) action = ACT_ASAVE_OFF;
          else                    action = ACT_ABORT;
        end
        SUB_OFFLINE: begin
          if (scnt == 8'hF8)      action = ACT_OFFL_ON;
          else if (scnt == 8'h00) action = ACT_OFFL_OFF;
          else                    action = ACT_ABORT;
        end
        default: action = ACT_ABORT;
      endcase
    end
  end
endmodule

// File: rtl/health_cmd_resp.sv
module health_cmd_resp
  import health_pkg::*;
#(
  parameter int N_ATTR = 4,
  parameter logic [7:0] CMD_CODE = 8'hB0,
  parameter logic [7:0] INIT_THRESH = 8'h00,
  localparam int IDX_W = (N_ATTR > 1) ? $clog2(N_ATTR) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [2:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             attr_we,
  input  logic [IDX_W-1:0] attr_sel,
  input  logic [7:0]       attr_value,
  input  logic [7:0]       attr_thresh,
  output logic [7:0]       cyl_lo_out,
  output logic [7:0]       cyl_hi_out,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             health_en,
  output logic             autosave_en,
  output logic             offline_en
);
  state_e     state_q;
  action_e    act_dec, act_q;
  logic       err_q;
  logic [7:0] feat, scnt;
  logic       exceeded;
  logic       wr_fire, cmd_start, set_fail;

  assign wr_ready  = (state_q == ST_IDLE);
  assign wr_fire   = wr_valid && wr_ready;
  assign cmd_start = wr_fire && (wr_sel == SEL_CMD) && (wr_data == CMD_CODE);
  assign set_fail  = (state_q == ST_BUSY) && (act_q == ACT_STATUS) && exceeded;

  hc_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_sel(wr_sel),
    .wr_data(wr_data), .set_fail(set_fail), .feat(feat), .scnt(scnt),
    .cyl_lo(cyl_lo_out), .cyl_hi(cyl_hi_out)
  );

  hc_attr_table #(.N_ATTR(N_ATTR), .INIT_THRESH(INIT_THRESH)) u_table (
    .clk(clk), .rst_n(rst_n), .attr_we(attr_we), .attr_sel(attr_sel),
    .attr_value(attr_value), .attr_thresh(attr_thresh), .exceeded(exceeded)
  );

  hc_decode u_dec (
    .feat(feat), .scnt(scnt), .cyl_lo(cyl_lo_out), .cyl_hi(cyl_hi_out),
    .health_en(health_en), .action(act_dec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      act_q       <= ACT_ABORT;
      err_q       <= 1'b0;
      health_en   <= 1'b0;
      autosave_en <= 1'b0;
      offline_en  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_start) begin
          state_q <= ST_BUSY;
          act_q   <= act_dec;
        end
        ST_BUSY: begin
          state_q <= ST_DONE;
          err_q   <= (act_q == ACT_ABORT);
          case (act_q)
            ACT_ENABLE:    health_en   <= 1'b1;
            ACT_DISABLE:   health_en   <= 1'b0;
            ACT_ASAVE_ON:  autosave_en <= 1'b1;
            ACT_ASAVE_OFF: autosave_en <= 1'b0;
            ACT_OFFL_ON:   offline_en  <= 1'b1;
            ACT_OFFL_OFF:  offline_en  <= 1'b0;
            default: ;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q == ST_BUSY);
  assign done = (state_q == ST_DONE);
  assign err  = done && err_q;
endmodule

// File: rtl/health_cmd_resp_chk.sv
module health_cmd_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ready,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [7:0] cyl_lo_out,
  input logic [7:0] cyl_hi_out,
  input logic       health_en,
  input logic       autosave_en,
  input logic       offline_en
);
  a_r3_busy_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done);
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  a_r3_no_ready_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done) |-> !wr_ready);
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done}));
  a_r4_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  a_r4_flags_hold_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(health_en) && $stable(autosave_en) && $stable(offline_en)));
  a_r5_flags_change_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(health_en) && $stable(autosave_en) && $stable(offline_en)));
  a_r9_fail_code_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && cyl_lo_out == 8'hF4 && $past(cyl_lo_out) == 8'h4F)
      |-> (cyl_hi_out == 8'h2C));
endmodule

bind health_cmd_resp health_cmd_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .busy(busy), .done(done),
  .err(err), .cyl_lo_out(cyl_lo_out), .cyl_hi_out(cyl_hi_out),
  .health_en(health_en), .autosave_en(autosave_en), .offline_en(offline_en)
);

// File: tb/health_cmd_resp_test.sv
module health_cmd_resp_test;
  localparam int NA = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic attr_we = 1'b0;
  logic [IW-1:0] attr_sel = '0;
  logic [7:0] attr_value = '0, attr_thresh = '0;
  logic [7:0] cyl_lo_out, cyl_hi_out;
  logic busy, done, err, health_en, autosave_en, offline_en;

  always #5 clk = ~clk;

  health_cmd_resp #(.N_ATTR(NA)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .attr_we(attr_we), .attr_sel(attr_sel),
    .attr_value(attr_value), .attr_thresh(attr_thresh),
    .cyl_lo_out(cyl_lo_out), .cyl_hi_out(cyl_hi_out), .busy(busy), .done(done),
    .err(err), .health_en(health_en), .autosave_en(autosave_en),
    .offline_en(offline_en)
  );

  typedef struct packed {
    logic e; logic [7:0] lo; logic [7:0] hi; logic hen; logic asv; logic off;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0, busy_cnt = 0;
  logic prev_busy = 1'b0;
  bit m_hen = 0, m_asv = 0, m_off = 0;
  logic [7:0] m_val [NA];
  logic [7:0] m_thr [NA];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_exceeded();
    for (int i = 0; i < NA; i++) begin
      if (m_thr[i] == 8'hFF) return 1'b1;
      if (m_thr[i] != 8'h00 && m_thr[i] != 8'hFE && m_val[i] < m_thr[i]) return 1'b1;
    end
    return 1'b0;
  endfunction

  // Monitor: scoreboard compare in each done cycle (R3..R11)
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (done) begin
        check("R3 busy before done", {31'd0, prev_busy}, 32'd1);
        if (q.size() == 0) check("R3 unexpected done", 32'd1, 32'd0);
        else begin
          exp_t x;
          x = q.pop_front();
          check("R4/R6/R11 err", {31'd0, err}, {31'd0, x.e});
          check("R9 cyl_lo", {24'd0, cyl_lo_out}, {24'd0, x.lo});
          check("R9 cyl_hi", {24'd0, cyl_hi_out}, {24'd0, x.hi});
          check("R5 health_en", {31'd0, health_en}, {31'd0, x.hen});
          check("R7 autosave_en", {31'd0, autosave_en}, {31'd0, x.asv});
          check("R8 offline_en", {31'd0, offline_en}, {31'd0, x.off});
        end
      end
      prev_busy = busy;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic load_attr(input int i, input logic [7:0] v, input logic [7:0] t);
    @(negedge clk);
    attr_we = 1'b1; attr_sel = IW'(i); attr_value = v; attr_thresh = t;
    @(posedge clk); #1;
    attr_we = 1'b0;
    m_val[i] = v; m_thr[i] = t;
  endtask

  // Driver: computes the expected outcome from the requirements, then issues
  task automatic run_cmd(input logic [7:0] f, input logic [7:0] sc,
                         input logic [7:0] cl, input logic [7:0] ch);
    exp_t x;
    bit ab;
    ab = 1'b0;
    x.lo = cl; x.hi = ch;
    if (!(cl == 8'h4F && ch == 8'hC2)) ab = 1'b1;
    else if (f == 8'hD8) m_hen = 1'b1;
    else if (!m_hen) ab = 1'b1;
    else if (f == 8'hD9) m_hen = 1'b0;
    else if (f == 8'hDA) begin
      if (model_exceeded()) begin x.lo = 8'hF4; x.hi = 8'h2C; end
    end
    else if (f == 8'hD2 && sc == 8'hF1) m_asv = 1'b1;
    else if (f == 8'hD2 && sc == 8'h00) m_asv = 1'b0;
    else if (f == 8'hDB && sc == 8'hF8) m_off = 1'b1;
    else if (f == 8'hDB && sc == 8'h00) m_off = 1'b0;
    else ab = 1'b1;
    x.e = ab; x.hen = m_hen; x.asv = m_asv; x.off = m_off;
    wr(3'd0, f); wr(3'd1, sc); wr(3'd2, cl); wr(3'd3, ch);
    q.push_back(x);
    wr(3'd4, 8'hB0);
    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      check("R3 done missing", q.size(), 32'd0);
      q.delete();
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NA; i++) begin m_val[i] = 8'h64; m_thr[i] = 8'h00; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", {29'd0, health_en, autosave_en, offline_en}, 32'd0);
    check("R1 cyl", {16'd0, cyl_lo_out, cyl_hi_out}, 32'd0);
    check("R1 strobes/ready", {28'd0, wr_ready, busy, done, err}, 32'h8);

    // R2 register writes visible
    wr(3'd2, 8'h4F); wr(3'd3, 8'hC2);
    @(negedge clk);
    check("R2 cyl regs", {16'd0, cyl_lo_out, cyl_hi_out}, 32'h4FC2);

    // R3 non-health opcode starts nothing
    begin
      int b0;
      b0 = busy_cnt;
      wr(3'd4, 8'hEC);
      repeat (4) @(negedge clk);
      check("R3 other opcode ignored", busy_cnt, b0);
    end

    run_cmd(8'hDA, 8'h00, 8'h4F, 8'hC2); // R6 disabled -> abort
    run_cmd(8'hD8, 8'h00, 8'h4E, 8'hC2); // R4 bad low signature
    run_cmd(8'hD8, 8'h00, 8'h4F, 8'hC3); // R4 bad high signature
    run_cmd(8'hD8, 8'h00, 8'h4F, 8'hC2); // R5 enable
    run_cmd(8'hDA, 8'h00, 8'h4F, 8'hC2); // R9 pass with defaults (R12)
    run_cmd(8'hD2, 8'hF1, 8'h4F, 8'hC2); // R7 autosave on
    run_cmd(8'hD2, 8'h05, 8'h4F, 8'hC2); // R7 bad count aborts
    run_cmd(8'hD2, 8'h00, 8'h4F, 8'hC2); // R7 autosave off
    run_cmd(8'hDB, 8'hF8, 8'h4F, 8'hC2); // R8 off-line on
    run_cmd(8'hDB, 8'hF1, 8'h4F, 8'hC2); // R8 bad count aborts
    run_cmd(8'hDB, 8'h00, 8'h4F, 8'hC2); // R8 off-line off
    run_cmd(8'hD5, 8'h00, 8'h4F, 8'hC2); // R11 reserved
    run_cmd(8'hD6, 8'h00, 8'h4F, 8'hC2); // R11
    run_cmd(8'hDC, 8'h00, 8'h4F, 8'hC2); // R11
    run_cmd(8'hDF, 8'h00, 8'h4F, 8'hC2); // R11
    run_cmd(8'hD0, 8'h00, 8'h4F, 8'hC2); // R11 unsupported

    load_attr(0, 8'h64, 8'hFF);          // R10 always fails
    run_cmd(8'hDA, 8'h00, 8'h4F, 8'hC2);
    load_attr(0, 8'h01, 8'hFE);          // R10 skipped entry
    run_cmd(8'hDA, 8'h00, 8'h4F, 8'hC2);
    load_attr(0, 8'h01, 8'h00);          // R10 zero threshold passes
    run_cmd(8'hDA, 8'h00, 8'h4F, 8'hC2);
    load_attr(3, 8'h50, 8'h50);          // R10 equal passes
    run_cmd(8'hDA, 8'h00, 8'h4F, 8'hC2);
    load_attr(3, 8'h4F, 8'h50);          // R10 below fails (R12 entry 3)
    run_cmd(8'hDA, 8'h00, 8'h4F, 8'hC2);
    load_attr(3, 8'h64, 8'h00);
    run_cmd(8'hD9, 8'h00, 8'h4F, 8'hC2); // R5 disable
    run_cmd(8'hD2, 8'hF1, 8'h4F, 8'hC2); // R6 aborts when disabled

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule